// File: doc/BRIEF.md
# Reliability Vector Update Unit

This block keeps the reliability state of one variable node in a hard-reliability majority-logic decoder for non-binary LDPC codes over GF(32). The state is a vector of 32 small measures, one for each field element, together with the current hard-decision symbol. A load input seeds the vector from the channel hard decision. After that, the check-node side sends at most one vote per cycle. A vote is a 5-bit field symbol with a valid flag.

A vote raises the measure of the voted symbol by one. Measures saturate at a fixed ceiling r = 2^w - 1. When the voted measure is already at the ceiling, it stays there and every other nonzero measure drops by one. In that same case the hard decision moves to the voted symbol. The vector therefore always holds the ceiling value at the hard-decision symbol. Because of this, the decision is tracked vote by vote and no search for the largest measure is ever needed.

Top module: `rel_vec_update`

## Requirements
- R1: After reset the hard decision is symbol 0, the measure for symbol 0 equals r, and all other measures are 0.
- R2: A load (init_i high) sets the measure for init_sym_i to r, sets every other measure to 0, and sets the hard decision to init_sym_i. All of this is visible after the next rising clock edge.
- R3: When a load and a valid vote arrive in the same cycle, the load wins and the vote has no effect.
- R4: With init_i and vote_valid_i both low, the measure vector and the hard decision hold their values.
- R5: A valid vote whose symbol's measure is below r increments that measure by one. It leaves all other measures unchanged and keeps the hard decision.
- R6: A valid vote whose symbol's measure equals r leaves that measure at r and lowers every other nonzero measure by one. Measures at 0 stay at 0.
- R7: In the R6 case the hard decision becomes the vote symbol from the next edge on.
- R8: meas_vec_o bits [3*l+2 : 3*l] carry the measure of the field element whose 5-bit symbol value is l, for l = 0..31. r = 7 with 3-bit measures.
- R9: The measure at the current hard-decision symbol always equals r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load the vector from the channel hard decision |
| init_sym_i | input | 5 | Channel hard-decision symbol |
| vote_valid_i | input | 1 | Vote present this cycle |
| vote_sym_i | input | 5 | Voted field symbol |
| hard_sym_o | output | 5 | Current hard-decision symbol |
| meas_vec_o | output | 96 | All 32 measures packed, 3 bits each |

## Verification
The bench builds the block with its default parameters: 5-bit symbols and 3-bit measures, so 32 lanes with a ceiling of 7. With a ceiling of 7, a short run of votes on one symbol is enough to reach the saturated branch. That run exposes the swap of the decision, the decrement of the other lanes, and the case where a second lane reaches the ceiling without taking the decision. Long pseudo-random vote runs mixed with loads and idle cycles then drive many lanes down to zero and back, and every cycle is compared with a behavioural model.

// File: rtl/rvu_pkg.sv
package rvu_pkg;
  localparam int unsigned SYM_W_DEF  = 5;
  localparam int unsigned MEAS_W_DEF = 3;

  function automatic int unsigned ceil_of(input int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/rvu_sym_decode.sv
module rvu_sym_decode #(
  parameter int unsigned SYM_W = 5,
  localparam int unsigned Q    = 1 << SYM_W
) (
  input  logic             en_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [Q-1:0]     hot_o
);
  for (genvar l = 0; l < Q; l++) begin : g_hot
    assign hot_o[l] = en_i && (sym_i == SYM_W'(l));
  end
endmodule

// File: rtl/rvu_sat_detect.sv
module rvu_sat_detect #(
  parameter int unsigned SYM_W  = 5,
  parameter int unsigned MEAS_W = 3,
  localparam int unsigned Q     = 1 << SYM_W
) (
  input  logic [Q*MEAS_W-1:0] vec_i,
  input  logic [SYM_W-1:0]    sym_i,
  output logic                sat_o
);
  logic [MEAS_W-1:0] sel;
  assign sel   = vec_i[sym_i*MEAS_W +: MEAS_W];
  assign sat_o = &sel;  // ceiling is all ones
endmodule

// File: rtl/rvu_lane.sv
module rvu_lane #(
  parameter int unsigned MEAS_W = 3,
  parameter logic        RST_MAX = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              init_hit_i,
  input  logic              vote_i,
  input  logic              vote_hit_i,
  input  logic              vote_sat_i,
  output logic [MEAS_W-1:0] meas_o
);
  localparam logic [MEAS_W-1:0] CEIL = '1;

  logic [MEAS_W-1:0] meas_d, meas_q;

  always_comb begin
    meas_d = meas_q;
    if (init_i) begin
      meas_d = init_hit_i ? CEIL : '0;
    end else if (vote_i) begin
      if (vote_sat_i) begin
        if (!vote_hit_i && meas_q != '0) meas_d = meas_q - MEAS_W'(1);
      end else if (vote_hit_i) begin
        meas_d = meas_q + MEAS_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) meas_q <= RST_MAX ? CEIL : '0;
    else         meas_q <= meas_d;
  end

  assign meas_o = meas_q;
endmodule

// File: rtl/rel_vec_update.sv
module rel_vec_update
  import rvu_pkg::*;
#(
  parameter int unsigned SYM_W  = SYM_W_DEF,
  parameter int unsigned MEAS_W = MEAS_W_DEF,
  localparam int unsigned Q     = 1 << SYM_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic [SYM_W-1:0]    init_sym_i,
  input  logic                vote_valid_i,
  input  logic [SYM_W-1:0]    vote_sym_i,
  output logic [SYM_W-1:0]    hard_sym_o,
  output logic [Q*MEAS_W-1:0] meas_vec_o
);
  logic [Q-1:0]     init_hot, vote_hot;
  logic             vote_sat, vote_act;
  logic [SYM_W-1:0] hard_q;

  assign vote_act = vote_valid_i && !init_i;

  rvu_sym_decode #(.SYM_W(SYM_W)) u_init_dec (
    .en_i(1'b1), .sym_i(init_sym_i), .hot_o(init_hot)
  );
  rvu_sym_decode #(.SYM_W(SYM_W)) u_vote_dec (
    .en_i(vote_act), .sym_i(vote_sym_i), .hot_o(vote_hot)
  );
  rvu_sat_detect #(.SYM_W(SYM_W), .MEAS_W(MEAS_W)) u_sat (
    .vec_i(meas_vec_o), .sym_i(vote_sym_i), .sat_o(vote_sat)
  );

  for (genvar l = 0; l < Q; l++) begin : g_lane
    rvu_lane #(.MEAS_W(MEAS_W), .RST_MAX(l == 0)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .init_i     (init_i),
      .init_hit_i (init_hot[l]),
      .vote_i     (vote_act),
      .vote_hit_i (vote_hot[l]),
      .vote_sat_i (vote_sat),
      .meas_o     (meas_vec_o[l*MEAS_W +: MEAS_W])
    );
  end

  // decision follows the saturated vote; no argmax
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hard_q <= '0;
    else if (init_i)               hard_q <= init_sym_i;
    else if (vote_act && vote_sat) hard_q <= vote_sym_i;
  end

  assign hard_sym_o = hard_q;
endmodule

// File: rtl/rvu_chk.sv
module rvu_chk #(
  parameter int unsigned SYM_W  = 5,
  parameter int unsigned MEAS_W = 3,
  localparam int unsigned Q     = 1 << SYM_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                init_i,
  input logic [SYM_W-1:0]    init_sym_i,
  input logic                vote_valid_i,
  input logic [SYM_W-1:0]    vote_sym_i,
  input logic [SYM_W-1:0]    hard_sym_o,
  input logic [Q*MEAS_W-1:0] meas_vec_o
);
  localparam logic [MEAS_W-1:0] CEIL = '1;
  logic [MEAS_W-1:0] hard_meas, vote_meas;
  assign hard_meas = meas_vec_o[hard_sym_o*MEAS_W +: MEAS_W];
  assign vote_meas = meas_vec_o[vote_sym_i*MEAS_W +: MEAS_W];

  // R9
  hard_lane_ceil_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_meas == CEIL);
  // R2
  init_sets_hard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> hard_sym_o == $past(init_sym_i));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !vote_valid_i) |=> ($stable(meas_vec_o) && $stable(hard_sym_o)));
  // R5
  low_vote_keeps_hard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && vote_valid_i && vote_meas != CEIL) |=> $stable(hard_sym_o));
  // R7
  sat_vote_swaps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && vote_valid_i && vote_meas == CEIL) |=> hard_sym_o == $past(vote_sym_i));
endmodule

bind rel_vec_update rvu_chk #(.SYM_W(SYM_W), .MEAS_W(MEAS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .init_sym_i(init_sym_i),
  .vote_valid_i(vote_valid_i), .vote_sym_i(vote_sym_i),
  .hard_sym_o(hard_sym_o), .meas_vec_o(meas_vec_o)
);

// File: tb/rel_vec_update_bench.sv
module rel_vec_update_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0, vld = 1'b0;
  logic [4:0]  isym = '0, vsym = '0;
  logic [4:0]  hard;
  logic [95:0] vec;

  int m[32];
  int mhard;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rel_vec_update u_rel_vec_update (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .init_sym_i(isym),
    .vote_valid_i(vld), .vote_sym_i(vsym), .hard_sym_o(hard), .meas_vec_o(vec)
  );

  task automatic compare(input string tag);
    bit ok = 1'b1;
    n_vec++;
    for (int l = 0; l < 32; l++)
      if (int'(vec[l*3 +: 3]) != m[l]) begin
        ok = 1'b0;
        $display("FAIL %s lane %0d got %0d exp %0d", tag, l, vec[l*3 +: 3], m[l]);
      end
    if (int'(hard) != mhard) begin
      ok = 1'b0;
      $display("FAIL %s hard got %0d exp %0d", tag, hard, mhard);
    end
    if (!ok) n_bad++;
  endtask

  // behavioural reference, applied before the edge it models
  task automatic step(input bit i, input int is, input bit v, input int vs, input string tag);
    init = i; isym = 5'(is); vld = v; vsym = 5'(vs);
    if (i) begin
      foreach (m[l]) m[l] = (l == is) ? 7 : 0;
      mhard = is;
    end else if (v) begin
      if (m[vs] == 7) begin
        foreach (m[l]) if (l != vs && m[l] > 0) m[l]--;
        mhard = vs;
      end else m[vs]++;
    end
    @(posedge clk); #1;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    foreach (m[l]) m[l] = 0;
    m[0] = 7; mhard = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    // R2 load
    step(1, 5, 0, 0, "R2 load");
    // R5 climb symbol 9 to the ceiling, two lanes at r
    for (int k = 0; k < 7; k++) step(0, 0, 1, 9, "R5 climb");
    // R6 R7 saturated vote swaps decision and lowers lane 5
    step(0, 0, 1, 9, "R6 R7 saturated");
    step(0, 0, 1, 9, "R6 R7 repeat saturated");
    // R4 idle
    for (int k = 0; k < 4; k++) step(0, 0, 0, 9, "R4 idle");
    // R3 load wins over vote
    step(1, 31, 1, 9, "R3 load beats vote");
    step(0, 0, 1, 31, "R6 zeros stay zero");
    // R8 lane placement on edge symbols
    step(1, 0, 0, 0, "R8 load sym 0");
    step(0, 0, 1, 31, "R8 vote top lane");
    step(0, 0, 1, 16, "R8 vote mid lane");
    // mixed pseudo-random traffic: R5 R6 R7 R9
    for (int k = 0; k < 3000; k++) begin
      bit  ii, vv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ii = (lfsr[9:4] == 6'd0);
      vv = lfsr[15] | lfsr[14];
      step(ii, int'(lfsr[12:8]), vv, int'(lfsr[2:0] ^ {lfsr[11:10], 3'b0}), "R5 R6 R7 R9 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule